// File: doc/BRIEF.md
# PLL output frequency calculator

This block works out, in hertz, the frequency that a clock generator's PLL would produce and the peripheral (APB) bus frequency derived from it. It reads a PLL parameter word, a clock-select word and a few strap inputs. Real clock generation is out of scope. A single-cycle `start` pulse samples every input. A shared 32-bit restoring divider then evaluates each truncating ratio in turn, one quotient bit per cycle. When the last division finishes, `done` pulses and both results appear on the outputs, where they stay until the next calculation completes.

Two parameter encodings are supported and selected by `mode_new`. The legacy encoding (`mode_new` = 0) has these parts:
- an optional programmed ratio built from N, OD and D fields;
- a fallback lookup table indexed by two strap bits;
- a fixed APB post-divider of 2.

The current encoding (`mode_new` = 1) uses M, N and P fields with two nested truncating divisions and an APB post-divider of 4. The reference input frequency comes from strap pins with a fixed priority.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference frequency is 25,000,000 Hz when `strap_25m` is 1, whatever `strap_48m` is. Otherwise it is 48,000,000 Hz when `strap_48m` is 1. Otherwise it is 24,000,000 Hz.
- R2: The off bit forces `pll_hz` and `apb_hz` to 0, and it takes priority over every other field. In the current encoding the off bit is `pll_param[19]`. In the legacy encoding it is `pll_param[13]`.
- R3: In the current encoding, P is `pll_param[18:13]`, M is `pll_param[12:5]` and N is `pll_param[4:0]`. The multiplier is ((M+1)/(N+1))/(P+1), with each division truncated. `pll_hz` is the reference frequency times the multiplier, kept to its low 32 bits.
- R4: In the legacy encoding with the programmed bit `pll_param[11]` set, N is `pll_param[10:5]`, OD is `pll_param[4]` and D is `pll_param[3:0]`. The multiplier is (2-OD)*((N+2)/(D+1)), with the division truncated.
- R5: In the legacy encoding with `pll_param[11]` clear, `pll_hz` comes from a table indexed by `strap_sel`. For `strap_sel` 0, 1, 2 and 3 the table gives 384, 360, 336 and 408 MHz with a 24 or 48 MHz reference, and 400, 375, 350 and 425 MHz with a 25 MHz reference. The bypass bit has no effect on this path.
- R6: The bypass bit sets the multiplier to 1, so `pll_hz` equals the reference frequency. In the current encoding the bypass bit is `pll_param[20]`. In the legacy encoding it is `pll_param[12]`, and it applies only when the programmed bit is set.
- R7: `apb_hz` = (`pll_hz` / (`clk_sel[25:23]` + 1)) / 2 in the legacy encoding and / 4 in the current one, with each division truncated. All other bits of `clk_sel` are ignored.
- R8: `busy` is high from the cycle after an accepted `start` until the results are ready. `done` is high for exactly one cycle, in the first cycle where `busy` is low again. The outputs change only in the cycle when `done` is high.
- R9: A `start` pulse while `busy` is high is ignored: it neither restarts nor queues a calculation. Input changes after an accepted `start` have no effect on its results.
- R10: After reset, `busy`, `done`, `pll_hz` and `apb_hz` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a calculation |
| mode_new | input | 1 | 1 selects the current encoding, 0 the legacy encoding |
| pll_param | input | 32 | PLL parameter word |
| clk_sel | input | 32 | Clock-select word; bits [25:23] hold the APB divider field |
| strap_25m | input | 1 | Strap: 25 MHz reference |
| strap_48m | input | 1 | Strap: 48 MHz reference |
| strap_sel | input | 2 | Strap: legacy table index |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Single-cycle completion pulse |
| pll_hz | output | 32 | PLL frequency in Hz |
| apb_hz | output | 32 | APB frequency in Hz |

## Verification
Two situations are hard to reach from the ports. The first is a second `start` that lands in the middle of a running calculation. The stimulus launches one calculation, waits a few cycles, then changes every input and pulses `start` again. It then checks three things: the results match the first input set, exactly one `done` pulse appears, and the block stays idle afterwards. The second is the point where truncation would matter: nested quotients, an odd post-division, and a product that wraps past 32 bits. These are reached with field values chosen so that each loses a fraction or overflows.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    // current encoding field layout
    localparam int NEW_N_LSB   = 0;
    localparam int NEW_N_W     = 5;
    localparam int NEW_M_LSB   = 5;
    localparam int NEW_M_W     = 8;
    localparam int NEW_P_LSB   = 13;
    localparam int NEW_P_W     = 6;
    localparam int NEW_OFF_BIT = 19;
    localparam int NEW_BYP_BIT = 20;

    // legacy encoding field layout
    localparam int OLD_D_LSB    = 0;
    localparam int OLD_D_W      = 4;
    localparam int OLD_OD_BIT   = 4;
    localparam int OLD_N_LSB    = 5;
    localparam int OLD_N_W      = 6;
    localparam int OLD_PROG_BIT = 11;
    localparam int OLD_BYP_BIT  = 12;
    localparam int OLD_OFF_BIT  = 13;

    // APB post-divider expressed as a right shift
    localparam int APB_SHIFT_OLD = 1;
    localparam int APB_SHIFT_NEW = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RATIO,
        ST_POST,
        ST_APB
    } calc_st_e;

endpackage

// File: rtl/pll_ref_clock.sv
module pll_ref_clock #(
    parameter int W = 32
) (
    input  logic         strap_25m,
    input  logic         strap_48m,
    input  logic [1:0]   strap_sel,
    output logic [W-1:0] ref_hz,
    output logic [W-1:0] table_hz
);
    localparam int HZ_PER_MHZ = 1_000_000;

    logic [9:0] mhz;

    always_comb begin
        if (strap_25m) begin
            ref_hz = W'(25 * HZ_PER_MHZ);
        end else if (strap_48m) begin
            ref_hz = W'(48 * HZ_PER_MHZ);
        end else begin
            ref_hz = W'(24 * HZ_PER_MHZ);
        end
    end

    always_comb begin
        unique case ({strap_25m, strap_sel})
            3'b0_00: mhz = 10'd384;
            3'b0_01: mhz = 10'd360;
            3'b0_10: mhz = 10'd336;
            3'b0_11: mhz = 10'd408;
            3'b1_00: mhz = 10'd400;
            3'b1_01: mhz = 10'd375;
            3'b1_10: mhz = 10'd350;
            default: mhz = 10'd425;
        endcase
        table_hz = W'(mhz) * W'(HZ_PER_MHZ);
    end

endmodule

// File: rtl/pll_param_decode.sv
module pll_param_decode
    import pll_calc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         mode_new,
    input  logic [31:0]  pll_param,
    output logic         sel_off,
    output logic         sel_direct,
    output logic         sel_table,
    output logic         dbl,
    output logic [W-1:0] num_a,
    output logic [W-1:0] den_a,
    output logic [W-1:0] den_b
);
    logic [NEW_M_W-1:0] f_m;
    logic [NEW_N_W-1:0] f_n;
    logic [NEW_P_W-1:0] f_p;
    logic [OLD_N_W-1:0] f_on;
    logic [OLD_D_W-1:0] f_od;
    logic               prog;

    always_comb begin
        f_m  = pll_param[NEW_M_LSB +: NEW_M_W];
        f_n  = pll_param[NEW_N_LSB +: NEW_N_W];
        f_p  = pll_param[NEW_P_LSB +: NEW_P_W];
        f_on = pll_param[OLD_N_LSB +: OLD_N_W];
        f_od = pll_param[OLD_D_LSB +: OLD_D_W];
        prog = pll_param[OLD_PROG_BIT];

        if (mode_new) begin
            sel_off    = pll_param[NEW_OFF_BIT];
            sel_direct = pll_param[NEW_BYP_BIT];
            sel_table  = 1'b0;
            dbl        = 1'b0;
            num_a      = W'(f_m) + W'(1);
            den_a      = W'(f_n) + W'(1);
            den_b      = W'(f_p) + W'(1);
        end else begin
            sel_off    = pll_param[OLD_OFF_BIT];
            sel_direct = prog && pll_param[OLD_BYP_BIT];
            sel_table  = !prog;
            dbl        = !pll_param[OLD_OD_BIT];
            num_a      = W'(f_on) + W'(2);
            den_a      = W'(f_od) + W'(1);
            den_b      = W'(1);
        end
    end

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic          fin;
    } div_st_t;

    div_st_t s_d, s_q;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        shifted = {s_q.rem, s_q.quo[W-1]};
        diff    = shifted - {1'b0, s_q.den};
        if (go && !s_q.run) begin
            s_d.run = 1'b1;
            s_d.cnt = CW'(W);
            s_d.rem = '0;
            s_d.quo = num;
            s_d.den = den;
        end else if (s_q.run) begin
            if (shifted >= {1'b0, s_q.den}) begin
                s_d.rem = diff[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b1};
            end else begin
                s_d.rem = shifted[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) begin
                s_d.run = 1'b0;
                s_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign quo = s_q.quo;
    assign fin = s_q.fin;

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pll_calc_pkg::*;
#(
    parameter int W        = 32,
    parameter int PCLK_LSB = 23,
    parameter int PCLK_W   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode_new,
    input  logic [31:0] pll_param,
    input  logic [31:0] clk_sel,
    input  logic        strap_25m,
    input  logic        strap_48m,
    input  logic [1:0]  strap_sel,
    output logic        busy,
    output logic        done,
    output logic [31:0] pll_hz,
    output logic [31:0] apb_hz
);
    typedef struct packed {
        calc_st_e     st;
        logic         mode_new;
        logic         dbl;
        logic [W-1:0] ref_hz;
        logic [W-1:0] den_b;
        logic [W-1:0] pclk_den;
        logic [W-1:0] pll_work;
        logic         div_go;
        logic [W-1:0] div_num;
        logic [W-1:0] div_den;
        logic [W-1:0] pll_out;
        logic [W-1:0] apb_out;
        logic         done;
    } calc_t;

    calc_t c_d, c_q;

    logic [W-1:0] ref_hz_w, table_hz_w;
    logic         sel_off, sel_direct, sel_table, dbl_w;
    logic [W-1:0] num_a, den_a, den_b;
    logic [W-1:0] div_quo;
    logic         div_fin;
    logic [W-1:0] ratio_mult;

    pll_ref_clock #(.W(W)) i_ref (
        .strap_25m (strap_25m),
        .strap_48m (strap_48m),
        .strap_sel (strap_sel),
        .ref_hz    (ref_hz_w),
        .table_hz  (table_hz_w)
    );

    pll_param_decode #(.W(W)) i_dec (
        .mode_new   (mode_new),
        .pll_param  (pll_param),
        .sel_off    (sel_off),
        .sel_direct (sel_direct),
        .sel_table  (sel_table),
        .dbl        (dbl_w),
        .num_a      (num_a),
        .den_a      (den_a),
        .den_b      (den_b)
    );

    pll_seq_div #(.W(W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (c_q.div_go),
        .num   (c_q.div_num),
        .den   (c_q.div_den),
        .quo   (div_quo),
        .fin   (div_fin)
    );

    always_comb begin
        c_d        = c_q;
        c_d.div_go = 1'b0;
        c_d.done   = 1'b0;
        ratio_mult = c_q.dbl ? {div_quo[W-2:0], 1'b0} : div_quo;

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.mode_new = mode_new;
                    c_d.dbl      = dbl_w;
                    c_d.ref_hz   = ref_hz_w;
                    c_d.den_b    = den_b;
                    c_d.pclk_den = W'(clk_sel[PCLK_LSB +: PCLK_W]) + W'(1);
                    c_d.div_go   = 1'b1;
                    if (sel_off || sel_direct || sel_table) begin
                        if (sel_off) begin
                            c_d.pll_work = '0;
                        end else if (sel_direct) begin
                            c_d.pll_work = ref_hz_w;
                        end else begin
                            c_d.pll_work = table_hz_w;
                        end
                        c_d.div_num = c_d.pll_work;
                        c_d.div_den = c_d.pclk_den;
                        c_d.st      = ST_APB;
                    end else begin
                        c_d.div_num = num_a;
                        c_d.div_den = den_a;
                        c_d.st      = ST_RATIO;
                    end
                end
            end
            ST_RATIO: begin
                if (div_fin) begin
                    c_d.div_go = 1'b1;
                    if (c_q.mode_new) begin
                        c_d.div_num = div_quo;
                        c_d.div_den = c_q.den_b;
                        c_d.st      = ST_POST;
                    end else begin
                        c_d.pll_work = c_q.ref_hz * ratio_mult;
                        c_d.div_num  = c_d.pll_work;
                        c_d.div_den  = c_q.pclk_den;
                        c_d.st       = ST_APB;
                    end
                end
            end
            ST_POST: begin
                if (div_fin) begin
                    c_d.pll_work = c_q.ref_hz * div_quo;
                    c_d.div_go   = 1'b1;
                    c_d.div_num  = c_d.pll_work;
                    c_d.div_den  = c_q.pclk_den;
                    c_d.st       = ST_APB;
                end
            end
            default: begin
                if (div_fin) begin
                    c_d.pll_out = c_q.pll_work;
                    c_d.apb_out = div_quo >> (c_q.mode_new ? APB_SHIFT_NEW : APB_SHIFT_OLD);
                    c_d.done    = 1'b1;
                    c_d.st      = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy   = (c_q.st != ST_IDLE);
    assign done   = c_q.done;
    assign pll_hz = 32'(c_q.pll_out);
    assign apb_hz = 32'(c_q.apb_out);

endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] pll_hz,
    input logic [31:0] apb_hz
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pll_hz) && $stable(apb_hz))); // R8

    AST_APB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (apb_hz <= pll_hz)); // R7

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pll_hz == 32'd0) |-> (apb_hz == 32'd0)); // R2

endmodule

bind pll_freq_calc pll_freq_calc_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .pll_hz (pll_hz),
    .apb_hz (apb_hz)
);

// File: tb/test_pll_freq_calc.sv
module test_pll_freq_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_new = 1'b0;
    logic [31:0] pll_param = '0;
    logic [31:0] clk_sel = '0;
    logic        strap_25m = 1'b0;
    logic        strap_48m = 1'b0;
    logic [1:0]  strap_sel = '0;
    logic        busy, done;
    logic [31:0] pll_hz, apb_hz;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pll_freq_calc i_pll_freq_calc (
        .clk (clk), .rst_n (rst_n), .start (start), .mode_new (mode_new),
        .pll_param (pll_param), .clk_sel (clk_sel), .strap_25m (strap_25m),
        .strap_48m (strap_48m), .strap_sel (strap_sel), .busy (busy),
        .done (done), .pll_hz (pll_hz), .apb_hz (apb_hz)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] p_new(input bit off, input bit byp,
                                          input int p, input int m, input int n);
        return (32'(byp) << 20) | (32'(off) << 19) | (32'(p) << 13) | (32'(m) << 5) | 32'(n);
    endfunction

    function automatic logic [31:0] p_old(input bit off, input bit byp, input bit prog,
                                          input int n, input bit od, input int d);
        return (32'(off) << 13) | (32'(byp) << 12) | (32'(prog) << 11) |
               (32'(n) << 5) | (32'(od) << 4) | 32'(d);
    endfunction

    // Independent model built from the requirements
    function automatic longint model_pll(input bit mn, input logic [31:0] pp,
                                         input bit s25, input bit s48, input int sel);
        longint ck, mult;
        int t24 [4] = '{384, 360, 336, 408};
        int t25 [4] = '{400, 375, 350, 425};
        ck = s25 ? 25000000 : (s48 ? 48000000 : 24000000);             // R1
        if (mn) begin
            if (pp[19]) return 0;                                          // R2
            if (pp[20]) return ck;                                         // R6
            mult = ((pp[12:5] + 1) / (pp[4:0] + 1)) / (pp[18:13] + 1);     // R3
        end else begin
            if (pp[13]) return 0;                                          // R2
            if (!pp[11]) return longint'(s25 ? t25[sel] : t24[sel]) * 1000000; // R5
            if (pp[12]) return ck;                                         // R6
            mult = (2 - pp[4]) * ((pp[10:5] + 2) / (pp[3:0] + 1));         // R4
        end
        return (ck * mult) & 64'hFFFF_FFFF;
    endfunction

    function automatic longint model_apb(input bit mn, input longint pll, input int pclk);
        return (pll / (pclk + 1)) / (mn ? 4 : 2);                          // R7
    endfunction

    task automatic wait_done(output bit ok);
        int cnt = 0;
        ok = 1'b0;
        while (!done && cnt < 400) begin
            @(negedge clk);
            cnt++;
        end
        ok = done;
    endtask

    task automatic run_calc(input string req, input bit mn, input logic [31:0] pp,
                            input int pclk, input bit s25, input bit s48, input int sel);
        bit ok;
        longint ep, ea;
        @(negedge clk);
        mode_new  = mn;
        pll_param = pp;
        clk_sel   = (32'(pclk) << 23) | 32'hF000_0007;   // stray bits are ignored (R7)
        strap_25m = s25;
        strap_48m = s48;
        strap_sel = 2'(sel);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        check({req, " R8 busy after start"}, busy, 1);
        wait_done(ok);
        check({req, " R8 done seen"}, ok, 1);
        ep = model_pll(mn, pp, s25, s48, sel);
        ea = model_apb(mn, ep, pclk);
        check({req, " pll_hz"}, pll_hz, ep);
        check({req, " apb_hz"}, apb_hz, ea);
        @(negedge clk);
        check({req, " R8 done one cycle"}, done, 0);
        check({req, " R8 idle after done"}, busy, 0);
    endtask

    task automatic t_reset;
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 pll_hz", pll_hz, 0);
        check("R10 apb_hz", apb_hz, 0);
    endtask

    task automatic t_new_encoding;
        run_calc("R3 basic 24M", 1, p_new(0, 0, 1, 31, 3), 1, 0, 0, 0);
        check("R3 literal", pll_hz, 96000000);
        check("R7 literal new", apb_hz, 12000000);
        run_calc("R3 truncating 25M", 1, p_new(0, 0, 0, 13, 3), 0, 1, 0, 0);
        check("R3 truncation literal", pll_hz, 75000000);
        run_calc("R3 wrap 32 bit", 1, p_new(0, 0, 0, 255, 0), 0, 1, 0, 0);
        check("R3 wrap literal", pll_hz, 2105032704);
        run_calc("R3 nested floor", 1, p_new(0, 0, 2, 20, 1), 3, 0, 1, 0);
    endtask

    task automatic t_old_programmed;
        run_calc("R4 od0 48M", 0, p_old(0, 0, 1, 10, 0, 4), 2, 0, 1, 0);
        check("R4 literal", pll_hz, 192000000);
        check("R7 literal old", apb_hz, 32000000);
        run_calc("R4 od1", 0, p_old(0, 0, 1, 10, 1, 4), 0, 0, 1, 0);
        check("R4 od1 literal", pll_hz, 96000000);
    endtask

    task automatic t_old_table;
        run_calc("R5 25M sel3", 0, p_old(0, 0, 0, 0, 0, 0), 4, 1, 0, 3);
        check("R5 literal", pll_hz, 425000000);
        run_calc("R5 24M sel1", 0, p_old(0, 0, 0, 0, 0, 0), 7, 0, 0, 1);
        check("R7 odd pclk literal", apb_hz, 22500000);
        run_calc("R5 48M sel2", 0, p_old(0, 0, 0, 5, 1, 3), 5, 0, 1, 2);
        run_calc("R1 both straps sel0", 0, p_old(0, 0, 0, 0, 0, 0), 0, 1, 1, 0);
        check("R1 25M priority literal", pll_hz, 400000000);
        run_calc("R5 bypass ignored unprogrammed", 0, p_old(0, 1, 0, 0, 0, 0), 1, 0, 0, 2);
        check("R5 bypass ignored literal", pll_hz, 336000000);
    endtask

    task automatic t_off;
        run_calc("R2 new off", 1, p_new(1, 1, 3, 200, 2), 0, 1, 0, 0);
        check("R2 new off literal", pll_hz, 0);
        run_calc("R2 old off", 0, p_old(1, 1, 0, 7, 0, 1), 2, 0, 0, 3);
        check("R2 old off literal", apb_hz, 0);
    endtask

    task automatic t_bypass;
        run_calc("R6 new bypass 48M", 1, p_new(0, 1, 5, 99, 7), 1, 0, 1, 0);
        check("R6 new literal", pll_hz, 48000000);
        check("R6 new apb literal", apb_hz, 6000000);
        run_calc("R6 old bypass 25M", 0, p_old(0, 1, 1, 40, 0, 0), 0, 1, 0, 0);
        check("R6 old apb literal", apb_hz, 12500000);
        run_calc("R1 24M default", 1, p_new(0, 1, 0, 0, 0), 0, 0, 0, 0);
        check("R1 24M literal", pll_hz, 24000000);
    endtask

    task automatic t_busy_ignore;
        bit ok;
        int extra = 0;
        @(negedge clk);
        mode_new  = 1;
        pll_param = p_new(0, 0, 0, 7, 1);      // (8/2)/1 = 4 -> 100 MHz at 25M
        clk_sel   = 32'(1) << 23;
        strap_25m = 1;
        strap_48m = 0;
        strap_sel = 0;
        start     = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        mode_new  = 0;                          // change everything while busy
        pll_param = p_old(0, 0, 0, 0, 0, 0);
        clk_sel   = 32'(6) << 23;
        strap_25m = 0;
        strap_sel = 3;
        start     = 1;
        @(negedge clk);
        start = 0;
        check("R9 still busy", busy, 1);
        wait_done(ok);
        check("R9 done", ok, 1);
        check("R9 pll from first inputs", pll_hz, 100000000);
        check("R9 apb from first inputs", apb_hz, 12500000);
        repeat (150) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check("R9 no second calculation", extra, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_new_encoding();
        t_old_programmed();
        t_old_table();
        t_off();
        t_bypass();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule